// File: doc/BRIEF.md
# Channel-Status Buffer Memory with Selectable Layouts

This block is the byte-wide store that sits between a host processor and a digital audio transmitter's frame formatter. The host reaches it through a simple parallel port with a 5-bit address, an 8-bit data bus, an active-low select and a read/write strobe. Through this port the host loads the channel-status, user and auxiliary bytes, sets a small control register and polls a status register. The formatter asks for one byte at a time by naming the kind of byte it wants. The block works out which location holds that byte from its own read pointers and the selected layout, and returns the byte one cycle later.

Three layouts are available. The flat layout keeps eight channel-status bytes that both channels share. The streaming layout fixes the first four channel-status bytes and passes the other twenty through a four-byte ring that the host refills. The split layout gives each channel its own eight-byte channel-status area with the same ring scheme. Latched half-window flags, and an interrupt that can be masked per flag, tell the host when part of a window has been consumed and can be rewritten. When enabled, the last channel-status byte of a block is replaced by an internally computed CRC.

Top module: `csb_buffer`

## Requirements
- R1: A cycle with `sel_n` low and `wr_rd` low writes `wdata` into locations 08h to 1Fh. A cycle with `sel_n` low and `wr_rd` high puts the addressed byte on `rdata` after the next clock edge. Writes to 00h and to 02h..07h change nothing, and 02h..07h read as 00h.
- R2: The control register sits at 01h. Bits [1:0] hold the layout, bit 2 the CRC enable, and bits [5:3] the interrupt enables for flags 0, 1 and 2. It reads back with bits [7:6] as zero.
- R3: Layout 0 (flat): channel-status byte k (0..23) of either channel comes from 08h+k when k<8 and is 00h for k from 8 to 23.
- R4: Layout 1 (streaming): channel-status byte k of either channel comes from 08h+k when k<4, and from 0Ch+(k mod 4) otherwise.
- R5: Layout 2 (split): channel A uses base 08h and channel B uses base 10h, each with the same scheme as R4. Each channel has its own byte counter.
- R6: User bytes cycle through 10h..17h and auxiliary bytes through 18h..1Fh in layouts 0 and 1. In layout 2 they cycle through 18h..1Bh and 1Ch..1Fh.
- R7: A layout value of 3 behaves exactly like layout 0.
- R8: Each channel's channel-status counter wraps from byte 23 back to byte 0, so one block is 24 fetches of that channel.
- R9: When the CRC enable is set and bit 0 of the byte 0 sent to that channel in the current block was 1, byte 23 is replaced by a CRC-8. The CRC uses polynomial x^8+x^4+x^3+x^2+1, starts at FFh and covers bytes 0..22 as sent. Each byte is fed bit 0 first; each bit XORed with the register MSB decides whether 1Dh is XORed into the left-shifted register. In every other case byte 23 is the mapped memory byte.
- R10: `tx_valid` is high in exactly the cycle after a cycle with `tx_req` high, and `tx_data` then holds the requested byte.
- R11: The status register at 00h holds flags in bits [2:0]. Flag 0 latches after a user fetch from the last slot of the lower half of the user window. Flag 1 latches after a fetch from the last slot of its upper half. Flag 2 latches after a channel-A fetch of byte k, where k is odd and at least 5 in layouts 1 and 2, and k is 23 in layout 0.
- R12: Reading the status register clears the flags. A flag event in the same cycle as that read stays set.
- R13: `irq` is high whenever a latched flag has its enable bit set.
- R14: After reset the memory, the control register, the flags, the pointers, `tx_valid` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Host select, active low |
| wr_rd | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| tx_req | input | 1 | Formatter byte request |
| tx_kind | input | 2 | 0 = status A, 1 = status B, 2 = user, 3 = auxiliary |
| tx_data | output | 8 | Fetched byte, registered |
| tx_valid | output | 1 | `tx_data` holds a new byte |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The assertions check on every cycle the properties that hold whatever was stored:
- `tx_valid` follows `tx_req` by exactly one cycle.
- Counters stay inside a block.
- Every fetch address lands in the RAM area, and the split layout keeps channel B in its own window.
- Reserved rows are never written.
- A status read with no concurrent fetch leaves the flags clear, and `irq` rises only after a fetch or a control write.
- Each CRC unit captures the professional bit at byte 0.

Only the bench scenarios can show the byte-level results. These are the mapping of each of the 24 channel-status positions in every layout, the wrap of the user and auxiliary windows, the exact fetch after which each flag appears, and the CRC value that replaces byte 23.

// File: rtl/csb_pkg.sv
package csb_pkg;

    localparam int PTR_W = 3;  // user/aux window pointer, up to 8 slots

    typedef enum logic [1:0] {
        LAYOUT_FLAT   = 2'd0,
        LAYOUT_STREAM = 2'd1,
        LAYOUT_SPLIT  = 2'd2,
        LAYOUT_SPARE  = 2'd3
    } layout_e;

    typedef enum logic [1:0] {
        FETCH_CSA  = 2'd0,
        FETCH_CSB  = 2'd1,
        FETCH_USER = 2'd2,
        FETCH_AUX  = 2'd3
    } fetch_e;

    // One byte through the CRC-8 (poly 1Dh), data taken bit 0 first.
    function automatic logic [7:0] crc_step(input logic [7:0] crc_in,
                                            input logic [7:0] data);
        logic [7:0] c;
        logic       fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[7] ^ data[i];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
        end
        return c;
    endfunction

endpackage

// File: rtl/csb_mem.sv
module csb_mem #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int LO     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        if (g >= LO) begin : g_store
            logic [DATA_W-1:0] row_d, row_q;
            always_comb begin
                row_d = row_q;
                if (we && (waddr == ADDR_W'(g)))
                    row_d = wdata;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) row_q <= '0;
                else        row_q <= row_d;
            end
            assign rows[g] = row_q;
        end else begin : g_none
            assign rows[g] = '0;
        end
    end

    assign rdata_a = rows[raddr_a];
    assign rdata_b = rows[raddr_b];

    // R1: the rows below the RAM area are never written
    p_low_rows_untouched_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr >= ADDR_W'(LO)));

endmodule

// File: rtl/csb_map.sv
module csb_map
    import csb_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int IDX_W  = 5
) (
    input  layout_e           layout,
    input  fetch_e            kind,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic [PTR_W-1:0]  uptr,
    input  logic [PTR_W-1:0]  aptr,
    output logic [ADDR_W-1:0] addr,
    output logic              blank
);
    localparam logic [ADDR_W-1:0] CS_A_BASE  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] CS_B_BASE  = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] USR_FLAT   = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] AUX_FLAT   = ADDR_W'(24);
    localparam logic [ADDR_W-1:0] USR_SPLIT  = ADDR_W'(24);
    localparam logic [ADDR_W-1:0] AUX_SPLIT  = ADDR_W'(28);
    localparam int                FIXED_CNT  = 4;
    localparam int                FLAT_CNT   = 8;

    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base;
    logic              ringed;
    logic              split;

    always_comb begin
        split  = (layout == LAYOUT_SPLIT);
        ringed = (layout == LAYOUT_STREAM) || split;
        idx    = (kind == FETCH_CSB) ? idx_b : idx_a;
        base   = (split && kind == FETCH_CSB) ? CS_B_BASE : CS_A_BASE;
        blank  = 1'b0;
        addr   = base;
        case (kind)
            FETCH_CSA, FETCH_CSB: begin
                if (ringed) begin
                    if (idx < IDX_W'(FIXED_CNT)) addr = base + ADDR_W'(idx);
                    else addr = base + ADDR_W'(FIXED_CNT) + ADDR_W'(idx[1:0]);
                end else begin
                    if (idx < IDX_W'(FLAT_CNT)) addr = base + ADDR_W'(idx);
                    else                        blank = 1'b1;
                end
            end
            FETCH_USER: addr = split ? USR_SPLIT + ADDR_W'(uptr[1:0])
                                     : USR_FLAT  + ADDR_W'(uptr);
            default:    addr = split ? AUX_SPLIT + ADDR_W'(aptr[1:0])
                                     : AUX_FLAT  + ADDR_W'(aptr);
        endcase
    end

endmodule

// File: rtl/csb_crc.sv
module csb_crc
    import csb_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int LAST_IDX = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_in,
    output logic [7:0]       crc,
    output logic             pro
);
    typedef struct packed {
        logic [7:0] crc;
        logic       pro;
    } crc_state_t;

    crc_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (idx == '0) begin
                s_d.crc = crc_step(8'hFF, byte_in);
                s_d.pro = byte_in[0];
            end else if (idx < IDX_W'(LAST_IDX)) begin
                s_d.crc = crc_step(s_q.crc, byte_in);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{crc: 8'hFF, pro: 1'b0};
        else        s_q <= s_d;
    end

    assign crc = s_q.crc;
    assign pro = s_q.pro;

    // R9: the professional bit is taken from byte 0 of each block
    p_pro_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && idx == '0) |=> (pro == $past(byte_in[0])));

endmodule

// File: rtl/csb_buffer.sv
module csb_buffer
    import csb_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int CS_BYTES = 24,
    parameter int RAM_LO   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tx_req,
    input  logic [1:0]        tx_kind,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              irq
);
    localparam int               IDX_W     = $clog2(CS_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CS_BYTES - 1);
    localparam logic [IDX_W-1:0] RING_FROM = IDX_W'(5);
    localparam logic [ADDR_W-1:0] STAT_A   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(1);
    localparam int               NFLAG     = 3;

    typedef struct packed {
        logic [1:0]        mode;
        logic              crc_en;
        logic [NFLAG-1:0]  irq_en;
        logic [IDX_W-1:0]  idx_a;
        logic [IDX_W-1:0]  idx_b;
        logic [PTR_W-1:0]  uptr;
        logic [PTR_W-1:0]  aptr;
        logic [NFLAG-1:0]  flags;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] tx_data;
        logic              tx_valid;
    } state_t;

    state_t s_d, s_q;

    layout_e           lay;
    fetch_e            kind;
    logic              host_wr, host_rd, ram_we;
    logic [ADDR_W-1:0] map_addr;
    logic              map_blank;
    logic [DATA_W-1:0] ram_host, ram_tx, fetch_byte;
    logic [1:0]        crc_go;
    logic [7:0]        crc_val [2];
    logic [1:0]        pro_v;
    logic [IDX_W-1:0]  ch_idx [2];
    logic [PTR_W-1:0]  win_last, half_last, uptr_eff, aptr_eff;

    assign kind    = fetch_e'(tx_kind);
    assign lay     = (s_q.mode == 2'd3) ? LAYOUT_FLAT : layout_e'(s_q.mode);
    assign host_wr = !sel_n && !wr_rd;
    assign host_rd = !sel_n &&  wr_rd;
    assign ram_we  = host_wr && (addr >= ADDR_W'(RAM_LO));

    csb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO(RAM_LO)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(addr), .wdata(wdata),
        .raddr_a(addr), .rdata_a(ram_host), .raddr_b(map_addr), .rdata_b(ram_tx)
    );

    csb_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_map (
        .layout(lay), .kind(kind), .idx_a(s_q.idx_a), .idx_b(s_q.idx_b),
        .uptr(s_q.uptr), .aptr(s_q.aptr), .addr(map_addr), .blank(map_blank)
    );

    assign fetch_byte = map_blank ? '0 : ram_tx;
    assign ch_idx[0]  = s_q.idx_a;
    assign ch_idx[1]  = s_q.idx_b;
    assign crc_go[0]  = tx_req && (kind == FETCH_CSA);
    assign crc_go[1]  = tx_req && (kind == FETCH_CSB);

    for (genvar c = 0; c < 2; c++) begin : g_crc
        csb_crc #(.IDX_W(IDX_W), .LAST_IDX(CS_BYTES - 1)) u_crc (
            .clk(clk), .rst_n(rst_n), .step(crc_go[c]), .idx(ch_idx[c]),
            .byte_in(fetch_byte[7:0]), .crc(crc_val[c]), .pro(pro_v[c])
        );
    end

    always_comb begin
        s_d          = s_q;
        s_d.tx_valid = tx_req;

        win_last  = (lay == LAYOUT_SPLIT) ? PTR_W'(3) : PTR_W'(7);
        half_last = (lay == LAYOUT_SPLIT) ? PTR_W'(1) : PTR_W'(3);
        uptr_eff  = s_q.uptr & win_last;
        aptr_eff  = s_q.aptr & win_last;

        // host control write
        if (host_wr && addr == CTRL_A) begin
            s_d.mode   = wdata[1:0];
            s_d.crc_en = wdata[2];
            s_d.irq_en = wdata[5:3];
        end

        // host read, status read clears the flags
        if (host_rd) begin
            if (addr == STAT_A)
                s_d.rdata = {{(DATA_W-NFLAG){1'b0}}, s_q.flags};
            else if (addr == CTRL_A)
                s_d.rdata = {{(DATA_W-6){1'b0}}, s_q.irq_en, s_q.crc_en, s_q.mode};
            else if (addr < ADDR_W'(RAM_LO))
                s_d.rdata = '0;
            else
                s_d.rdata = ram_host;
            if (addr == STAT_A)
                s_d.flags = '0;
        end

        // formatter fetch; flag events set after the clear so they win
        if (tx_req) begin
            s_d.tx_data = fetch_byte;
            case (kind)
                FETCH_CSA: begin
                    if (s_q.idx_a == LAST_IDX && s_q.crc_en && pro_v[0])
                        s_d.tx_data = DATA_W'(crc_val[0]);
                    s_d.idx_a = (s_q.idx_a == LAST_IDX) ? '0 : s_q.idx_a + 1'b1;
                    if (lay == LAYOUT_FLAT) begin
                        if (s_q.idx_a == LAST_IDX) s_d.flags[2] = 1'b1;
                    end else if (s_q.idx_a >= RING_FROM && s_q.idx_a[0]) begin
                        s_d.flags[2] = 1'b1;
                    end
                end
                FETCH_CSB: begin
                    if (s_q.idx_b == LAST_IDX && s_q.crc_en && pro_v[1])
                        s_d.tx_data = DATA_W'(crc_val[1]);
                    s_d.idx_b = (s_q.idx_b == LAST_IDX) ? '0 : s_q.idx_b + 1'b1;
                end
                FETCH_USER: begin
                    s_d.uptr = (uptr_eff == win_last) ? '0 : uptr_eff + 1'b1;
                    if (uptr_eff == half_last) s_d.flags[0] = 1'b1;
                    if (uptr_eff == win_last)  s_d.flags[1] = 1'b1;
                end
                default: begin
                    s_d.aptr = (aptr_eff == win_last) ? '0 : aptr_eff + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata    = s_q.rdata;
    assign tx_data  = s_q.tx_data;
    assign tx_valid = s_q.tx_valid;
    assign irq      = |(s_q.flags & s_q.irq_en);

    // R10: a byte is presented exactly one cycle after each request
    p_valid_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);
    p_no_valid_without_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid);

    // R8: channel counters stay inside one block
    p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.idx_a <= LAST_IDX) && (s_q.idx_b <= LAST_IDX));

    // R6: every fetch lands in the RAM area
    p_fetch_in_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !map_blank) |-> (map_addr >= ADDR_W'(RAM_LO)));

    // R5: split layout keeps channel B inside 10h..17h
    p_split_b_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && lay == LAYOUT_SPLIT && kind == FETCH_CSB) |->
        (map_addr >= ADDR_W'(16) && map_addr < ADDR_W'(24)));

    // R12: a status read with no fetch leaves every flag clear
    p_status_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && addr == STAT_A && !tx_req) |=> (s_q.flags == '0));

    // R13: the interrupt only rises after a fetch or a control write
    p_irq_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(tx_req) || $past(host_wr && addr == CTRL_A)));

endmodule

// File: tb/csb_buffer_bench.sv
`timescale 1ns/1ps
module csb_buffer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       wr_rd = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx_req = 1'b0;
    logic [1:0] tx_kind = '0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] bmem [32];

    always #5 clk = ~clk;

    csb_buffer u_csb_buffer (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_rd(wr_rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_req(tx_req), .tx_kind(tx_kind),
        .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sel_n = 1'b1; wr_rd = 1'b1; tx_req = 1'b0;
        for (int i = 0; i < 32; i++) bmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic hwr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        sel_n = 1'b0; wr_rd = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        sel_n = 1'b1; wr_rd = 1'b1;
        if (a >= 5'h08) bmem[a] = d;
    endtask

    task automatic hrd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        sel_n = 1'b0; wr_rd = 1'b1; addr = a;
        @(negedge clk);
        v = rdata; sel_n = 1'b1;
    endtask

    task automatic fetch(input logic [1:0] k, output logic [7:0] v);
        @(negedge clk);
        tx_req = 1'b1; tx_kind = k;
        @(negedge clk);
        v = tx_data; tx_req = 1'b0;
    endtask

    // status read and a fetch issued in the same cycle
    task automatic rd_and_fetch(input logic [1:0] k, output logic [7:0] st, output logic [7:0] v);
        @(negedge clk);
        sel_n = 1'b0; wr_rd = 1'b1; addr = 5'h00; tx_req = 1'b1; tx_kind = k;
        @(negedge clk);
        st = rdata; v = tx_data; sel_n = 1'b1; tx_req = 1'b0;
    endtask

    // expected channel-status byte per R3/R4/R5/R7
    function automatic logic [7:0] exp_cs(input logic [1:0] md, input bit chb, input int k);
        int lay  = (md == 2'd3) ? 0 : int'(md);
        int base = (lay == 2 && chb) ? 16 : 8;
        if (lay == 0) return (k < 8) ? bmem[base + k] : 8'h00;
        if (k < 4) return bmem[base + k];
        return bmem[base + 4 + (k % 4)];
    endfunction

    // R9 CRC reference
    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[7] ^ d[b]) r = {r[6:0], 1'b0} ^ 8'h1D;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    typedef struct packed {
        logic [1:0] op;   // 0 write, 1 read-check, 2 fetch-check (a[1:0] = kind)
        logic [4:0] a;
        logic [7:0] d;
        logic [7:0] e;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 5'h01, 8'h01, 8'h00},   // R2 layout 1
        '{2'd1, 5'h01, 8'h00, 8'h01},   // R2 readback
        '{2'd0, 5'h08, 8'hA0, 8'h00},
        '{2'd0, 5'h0C, 8'hC4, 8'h00},
        '{2'd0, 5'h10, 8'h55, 8'h00},
        '{2'd0, 5'h18, 8'h77, 8'h00},
        '{2'd1, 5'h08, 8'h00, 8'hA0},   // R1 readback
        '{2'd2, 5'h00, 8'h00, 8'hA0},   // R4 channel A byte 0
        '{2'd2, 5'h01, 8'h00, 8'hA0},   // R4 channel B shares
        '{2'd2, 5'h02, 8'h00, 8'h55},   // R6 user slot 0
        '{2'd2, 5'h03, 8'h00, 8'h77},   // R6 aux slot 0
        '{2'd1, 5'h02, 8'h00, 8'h00},   // R1 reserved reads zero
        '{2'd0, 5'h03, 8'hFF, 8'h00},   // R1 reserved write
        '{2'd1, 5'h03, 8'h00, 8'h00},   // R1 still zero
        '{2'd1, 5'h00, 8'h00, 8'h00}    // R11 no flag yet
    };

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, st;
        logic [7:0] crc;

        // ---- R14 reset state ----
        do_reset();
        chk("R14 tx_valid", {7'b0, tx_valid}, 8'h00);
        chk("R14 irq", {7'b0, irq}, 8'h00);
        hrd(5'h00, v); chk("R14 status", v, 8'h00);
        hrd(5'h01, v); chk("R14 control", v, 8'h00);
        hrd(5'h13, v); chk("R14 memory", v, 8'h00);

        // ---- vector table ----
        for (int i = 0; i < NVEC; i++) begin
            case (VECS[i].op)
                2'd0: hwr(VECS[i].a, VECS[i].d);
                2'd1: begin hrd(VECS[i].a, v); chk($sformatf("R1/R2 vec %0d", i), v, VECS[i].e); end
                default: begin fetch(VECS[i].a[1:0], v); chk($sformatf("R4/R6 vec %0d", i), v, VECS[i].e); end
            endcase
        end

        // ---- R10 valid timing ----
        fetch(2'd3, v);
        chk("R10 valid high", {7'b0, tx_valid}, 8'h01);
        @(negedge clk);
        chk("R10 valid low", {7'b0, tx_valid}, 8'h00);

        // ---- R4 R8 R11 streaming layout, full block on channel A ----
        do_reset();
        hwr(5'h01, 8'h01);
        for (int a = 8; a < 16; a++) hwr(5'(a), 8'(8'h30 + a));
        for (int k = 0; k < 24; k++) begin
            fetch(2'd0, v); chk($sformatf("R4 A byte %0d", k), v, exp_cs(2'd1, 1'b0, k));
            if (k == 4) begin hrd(5'h00, st); chk("R11 no flag2 at 4", st, 8'h00); end
            if (k == 5) begin hrd(5'h00, st); chk("R11 flag2 at 5", st, 8'h04); end
        end
        fetch(2'd0, v); chk("R8 wrap to byte 0", v, bmem[8]);
        for (int a = 16; a < 24; a++) hwr(5'(a), 8'(8'h50 + a));
        for (int i = 0; i < 9; i++) begin
            fetch(2'd2, v); chk($sformatf("R6 user flat %0d", i), v, bmem[16 + (i % 8)]);
        end

        // ---- R3 flat layout, R7 spare value ----
        do_reset();
        for (int a = 8; a < 16; a++) hwr(5'(a), 8'(8'h90 + a));
        for (int k = 0; k < 24; k++) begin
            fetch(2'd0, v); chk($sformatf("R3 A byte %0d", k), v, exp_cs(2'd0, 1'b0, k));
        end
        hrd(5'h00, st); chk("R11 flag2 at block end flat", st, 8'h04);
        hwr(5'h01, 8'h03);
        for (int k = 0; k < 24; k++) begin
            fetch(2'd1, v); chk($sformatf("R7 B byte %0d", k), v, exp_cs(2'd3, 1'b1, k));
        end

        // ---- R5 split layout, R6 small windows, R11 R12 R13 ----
        do_reset();
        hwr(5'h01, 8'h0A);                         // layout 2, enable flag 0
        for (int a = 8; a < 32; a++) hwr(5'(a), 8'(8'h40 + a));
        for (int k = 0; k < 6; k++) begin
            fetch(2'd0, v); chk($sformatf("R5 A byte %0d", k), v, exp_cs(2'd2, 1'b0, k));
            fetch(2'd1, v); chk($sformatf("R5 B byte %0d", k), v, exp_cs(2'd2, 1'b1, k));
        end
        chk("R13 flag2 masked", {7'b0, irq}, 8'h00);
        hrd(5'h00, st); chk("R11 flag2 split", st, 8'h04);
        fetch(2'd2, v); chk("R6 user split 0", v, bmem[24]);
        fetch(2'd2, v); chk("R6 user split 1", v, bmem[25]);
        chk("R13 irq on flag0", {7'b0, irq}, 8'h01);
        hrd(5'h00, st); chk("R11 flag0", st, 8'h01);
        chk("R12 irq cleared by read", {7'b0, irq}, 8'h00);
        fetch(2'd2, v); chk("R6 user split 2", v, bmem[26]);
        fetch(2'd2, v); chk("R6 user split 3", v, bmem[27]);
        hrd(5'h00, st); chk("R11 flag1", st, 8'h02);
        fetch(2'd2, v); chk("R6 user split wrap", v, bmem[24]);
        rd_and_fetch(2'd2, st, v);
        chk("R12 read before event", st, 8'h00);
        chk("R6 user split 1 again", v, bmem[25]);
        hrd(5'h00, st); chk("R12 event survives read", st, 8'h01);
        fetch(2'd3, v); chk("R6 aux split 0", v, bmem[28]);
        fetch(2'd3, v); chk("R6 aux split 1", v, bmem[29]);

        // ---- R1 R2 control and reserved writes ----
        hwr(5'h00, 8'hFF);
        hrd(5'h01, v); chk("R1 write to status ignored", v, 8'h0A);
        hwr(5'h01, 8'hFF);
        hrd(5'h01, v); chk("R2 upper bits zero", v, 8'h3F);

        // ---- R9 CRC substitution ----
        do_reset();
        hwr(5'h01, 8'h05);                         // layout 1, CRC on
        hwr(5'h08, 8'h21);
        for (int a = 9; a < 16; a++) hwr(5'(a), 8'(8'h30 + a));
        crc = 8'hFF;
        for (int k = 0; k < 24; k++) begin
            fetch(2'd0, v);
            if (k < 23) begin
                chk($sformatf("R9 A byte %0d", k), v, exp_cs(2'd1, 1'b0, k));
                crc = crc_ref(crc, exp_cs(2'd1, 1'b0, k));
            end else begin
                chk("R9 CRC byte 23", v, crc);
            end
        end
        hwr(5'h08, 8'h20);                         // consumer block: no CRC
        for (int k = 0; k < 24; k++) begin
            fetch(2'd1, v);
            if (k == 23) chk("R9 no CRC when bit0 clear", v, bmem[15]);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule